// File: doc/BRIEF.md
# Four-Channel Countdown Timer with Register Bus

This peripheral holds a set of independent down-counting timers behind one register bus slave with APB-style signalling. Each channel has its own load value, a run bit, a mode bit choosing free-running or one-shot operation, a live count that can be read, a reload strobe, and an interrupt line with a mask. Software arms a channel by writing the load value, forcing a reload, and setting the run bit.

A counting channel that reaches zero raises its pending flag. In free-running mode it then takes the load value again. In one-shot mode it stops at zero and drops its run bit. Clearing the pending flag is not immediate. A write of one to the clear bit opens a short busy window, visible as a second bit in the same register. The flag falls when the window closes, and further clear writes made during the window are dropped. Each channel uses a 0x40-byte window of the address space, and channel n starts at n*0x40.

Top module: `quad_countdown_timer`

## Requirements
- R1: The address is split into a channel index (bits above bit 5) and an offset (bits 5:0). The offsets are: 0x00 status, whose bit n is the pending flag of channel n and which reads the same in every window; 0x04 mode, where bit 0 = 0 means free-running and 1 means one-shot; 0x08 load value; 0x10 run bit (bit 0); 0x14 reload strobe, which reads 0; 0x18 live count (read-only); 0x20 clear/status; 0x24 mask (bit 0). Any other offset, including a misaligned one, reads 0, and a write to it changes nothing.
- R2: When the run bit is set, a non-zero count drops by one on every clock. The first decrement happens on the edge after the one that sets the run bit.
- R3: At an edge where the channel is running and its count is 0, the pending flag is set. In free-running mode the count takes the load value at that edge, so a channel loaded with L expires every L+1 clocks.
- R4: In one-shot mode, an expiry clears the run bit and leaves the count at 0.
- R5: Any write to the reload offset copies the load value into the count, whatever the written data is. The reload takes priority over a decrement or an expiry at the same edge. The load register takes values up to 0xFFFFFFFF.
- R6: When the run bit is clear, the count holds its value.
- R7: At offset 0x20, bit 0 reads the pending flag and bit 1 reads busy. Writing 1 to bit 0 sets busy for exactly 2 clocks, and the pending flag is cleared when the window ends. Writing 0 has no effect. An expiry at the edge that ends the window keeps the flag set.
- R8: A write of 1 to the clear bit while busy is set is ignored and does not extend the window.
- R9: Interrupt line n equals the pending flag of channel n while its mask bit is 0, and is 0 while the mask bit is 1.
- R10: After reset, every mask bit is 1 and every other register, count, flag and interrupt line is 0.
- R11: A channel's state changes only through writes to its own window and through its own counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | CH_W+6 (8) | Byte address: channel index and offset |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, decoded combinationally from paddr |
| irq | output | NUM_CH (4) | Per-channel interrupt lines |

## Verification
A behavioural model in the bench follows every channel, and each clock the interrupt lines are compared against it. One channel is run free with a short load value to measure the expiry period, and a second runs one-shot to show the stop at zero. These two patterns catch a swapped mode bit or an off-by-one in the period. Reloads are forced both while a channel is stopped and while it is counting, with the data values 0 and 1, which shows that the reload does not depend on the data. The clear path is driven three ways: a write of 0, a single write of 1, and a write held over two edges. The held write separates a busy window that ignores late writes from one that restarts. The channel that is never touched is read back at the end, so any leakage between windows shows up.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

   // Width of one channel's address window (0x40 bytes).
   localparam int WIN_BITS = 6;

   // Register offsets inside a channel window.
   localparam logic [WIN_BITS-1:0] OFF_STATUS = 6'h00;
   localparam logic [WIN_BITS-1:0] OFF_MODE   = 6'h04;
   localparam logic [WIN_BITS-1:0] OFF_LOAD   = 6'h08;
   localparam logic [WIN_BITS-1:0] OFF_RUN    = 6'h10;
   localparam logic [WIN_BITS-1:0] OFF_RELOAD = 6'h14;
   localparam logic [WIN_BITS-1:0] OFF_COUNT  = 6'h18;
   localparam logic [WIN_BITS-1:0] OFF_CLEAR  = 6'h20;
   localparam logic [WIN_BITS-1:0] OFF_MASK   = 6'h24;

   // Single-bit state that each channel exposes to the bus decoder.
   typedef struct packed {
      logic one_shot;
      logic run;
      logic masked;
      logic busy;
      logic pend;
   } cdt_flags_t;

endpackage

// File: rtl/cdt_chan.sv
module cdt_chan
   import cdt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int CLR_CYC = 2,
   localparam int BUSY_W = (CLR_CYC > 0) ? $clog2(CLR_CYC + 1) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_wr,
   input  logic             load_wr,
   input  logic             run_wr,
   input  logic             rld_wr,
   input  logic             clr_wr,
   input  logic             mask_wr,
   input  logic [CNT_W-1:0] wdata,
   output cdt_flags_t       flags,
   output logic [CNT_W-1:0] load_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             irq
);

   logic one_shot_q;
   logic run_q;
   logic mask_q;
   logic pend_q;
   logic busy;
   logic clr_now;
   logic expire;

   assign expire = run_q && (cnt_q == '0);

   // Configuration registers.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         one_shot_q <= 1'b0;
         load_q     <= '0;
         mask_q     <= 1'b1;
      end else begin
         if (mode_wr) one_shot_q <= wdata[0];
         if (load_wr) load_q     <= wdata;
         if (mask_wr) mask_q     <= wdata[0];
      end
   end

   // Counter: a reload strobe comes first, then expiry, then decrement.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (rld_wr) begin
         cnt_q <= load_q;
      end else if (run_q) begin
         if (cnt_q == '0) cnt_q <= one_shot_q ? '0 : load_q;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   // Run bit: a bus write wins over the automatic one-shot stop.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    run_q <= 1'b0;
      else if (run_wr)               run_q <= wdata[0];
      else if (expire && one_shot_q) run_q <= 1'b0;
   end

   // Clear path: either an immediate clear or a counted busy window.
   generate
      if (CLR_CYC == 0) begin : g_clr_now
         assign busy    = 1'b0;
         assign clr_now = clr_wr && wdata[0];
      end else begin : g_clr_win
         logic [BUSY_W-1:0] bcnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   bcnt <= '0;
            else if (bcnt != '0)          bcnt <= bcnt - 1'b1;
            else if (clr_wr && wdata[0])  bcnt <= BUSY_W'(CLR_CYC);
         end

         assign busy    = (bcnt != '0);
         assign clr_now = (bcnt == BUSY_W'(1));

         // R8: a clear write during the window does not restart it
         p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (bcnt != '0) && clr_wr |=> bcnt == $past(bcnt) - 1'b1);

         // R7: the flag is gone after the window unless a new expiry arrived
         p_clr_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (bcnt == BUSY_W'(1)) && !expire |=> !pend_q);
      end
   endgenerate

   // Pending flag: a new expiry wins over a finishing clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (expire)  pend_q <= 1'b1;
      else if (clr_now) pend_q <= 1'b0;
   end

   assign irq            = pend_q & ~mask_q;
   assign flags.one_shot = one_shot_q;
   assign flags.run      = run_q;
   assign flags.masked   = mask_q;
   assign flags.busy     = busy;
   assign flags.pend     = pend_q;

   // R2: running with non-zero count steps down by one
   p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && !rld_wr && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

   // R3: expiry raises the pending flag
   p_expire_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> pend_q);

   // R3: free-running expiry restarts from the load value
   p_cont_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      expire && !one_shot_q && !rld_wr |=> cnt_q == $past(load_q));

   // R4: one-shot expiry stops the channel at zero
   p_single_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      expire && one_shot_q && !run_wr && !rld_wr |=> !run_q && (cnt_q == '0));

   // R5: reload strobe copies the load value
   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rld_wr |=> cnt_q == $past(load_q));

   // R6: a stopped channel holds its count
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q && !rld_wr |=> $stable(cnt_q));

endmodule

// File: rtl/cdt_regbus.sv
module cdt_regbus
   import cdt_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int CH_W   = 2,
   parameter int ADDR_W = 8
)(
   input  logic                         psel,
   input  logic                         penable,
   input  logic                         pwrite,
   input  logic [ADDR_W-1:0]            paddr,
   input  cdt_flags_t [NUM_CH-1:0]      flags,
   input  logic [NUM_CH-1:0][CNT_W-1:0] load_v,
   input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_v,
   output logic [NUM_CH-1:0]            mode_wr,
   output logic [NUM_CH-1:0]            load_wr,
   output logic [NUM_CH-1:0]            run_wr,
   output logic [NUM_CH-1:0]            rld_wr,
   output logic [NUM_CH-1:0]            clr_wr,
   output logic [NUM_CH-1:0]            mask_wr,
   output logic [DATA_W-1:0]            prdata
);

   logic                acc_wr;
   logic [CH_W-1:0]     sel_ch;
   logic [WIN_BITS-1:0] sel_off;
   logic [NUM_CH-1:0]   hit;
   logic [NUM_CH-1:0]   pend_vec;

   assign acc_wr  = psel && penable && pwrite;
   assign sel_ch  = paddr[ADDR_W-1:WIN_BITS];
   assign sel_off = paddr[WIN_BITS-1:0];

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
         logic wr_here;
         assign hit[i]      = (sel_ch == CH_W'(i));
         assign wr_here     = acc_wr && hit[i];
         assign mode_wr[i]  = wr_here && (sel_off == OFF_MODE);
         assign load_wr[i]  = wr_here && (sel_off == OFF_LOAD);
         assign run_wr[i]   = wr_here && (sel_off == OFF_RUN);
         assign rld_wr[i]   = wr_here && (sel_off == OFF_RELOAD);
         assign clr_wr[i]   = wr_here && (sel_off == OFF_CLEAR);
         assign mask_wr[i]  = wr_here && (sel_off == OFF_MASK);
         assign pend_vec[i] = flags[i].pend;
      end
   endgenerate

   // Read multiplexer: select the addressed channel, then the offset.
   always_comb begin
      cdt_flags_t       f;
      logic [CNT_W-1:0] ld;
      logic [CNT_W-1:0] ct;
      f  = '0;
      ld = '0;
      ct = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (hit[i]) begin
            f  = flags[i];
            ld = load_v[i];
            ct = cnt_v[i];
         end
      end
      prdata = '0;
      if (|hit) begin
         case (sel_off)
            OFF_STATUS: prdata[NUM_CH-1:0] = pend_vec;
            OFF_MODE:   prdata[0]          = f.one_shot;
            OFF_LOAD:   prdata[CNT_W-1:0]  = ld;
            OFF_RUN:    prdata[0]          = f.run;
            OFF_COUNT:  prdata[CNT_W-1:0]  = ct;
            OFF_CLEAR:  prdata[1:0]        = {f.busy, f.pend};
            OFF_MASK:   prdata[0]          = f.masked;
            default:    prdata             = '0;
         endcase
      end
   end

   // R1: at most one register of one channel is written per access
   always_comb begin
      if (acc_wr) begin
         a_one_strobe_r1: assert ($countones({mode_wr, load_wr, run_wr,
                                              rld_wr, clr_wr, mask_wr}) <= 1);
      end
   end

endmodule

// File: rtl/quad_countdown_timer.sv
module quad_countdown_timer
   import cdt_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int CNT_W   = 32,
   parameter int DATA_W  = 32,
   parameter int CLR_CYC = 2,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int ADDR_W = CH_W + cdt_pkg::WIN_BITS
)(
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic [NUM_CH-1:0] irq
);

   // Elaboration-time parameter checks.
   generate
      if (NUM_CH < 2 || NUM_CH > DATA_W) begin : g_bad_num_ch
         $error("NUM_CH must lie between 2 and DATA_W");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("CNT_W must lie between 2 and DATA_W");
      end
      if (CLR_CYC < 0 || CLR_CYC > 15) begin : g_bad_clr
         $error("CLR_CYC must lie between 0 and 15");
      end
   endgenerate

   cdt_flags_t [NUM_CH-1:0]      flags;
   logic [NUM_CH-1:0][CNT_W-1:0] load_v;
   logic [NUM_CH-1:0][CNT_W-1:0] cnt_v;
   logic [NUM_CH-1:0]            mode_wr, load_wr, run_wr;
   logic [NUM_CH-1:0]            rld_wr, clr_wr, mask_wr;

   cdt_regbus #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .CH_W   (CH_W),
      .ADDR_W (ADDR_W)
   ) u_bus (
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .flags   (flags),
      .load_v  (load_v),
      .cnt_v   (cnt_v),
      .mode_wr (mode_wr),
      .load_wr (load_wr),
      .run_wr  (run_wr),
      .rld_wr  (rld_wr),
      .clr_wr  (clr_wr),
      .mask_wr (mask_wr),
      .prdata  (prdata)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         cdt_chan #(
            .CNT_W   (CNT_W),
            .CLR_CYC (CLR_CYC)
         ) u_chan (
            .clk     (pclk),
            .rst_n   (presetn),
            .mode_wr (mode_wr[c]),
            .load_wr (load_wr[c]),
            .run_wr  (run_wr[c]),
            .rld_wr  (rld_wr[c]),
            .clr_wr  (clr_wr[c]),
            .mask_wr (mask_wr[c]),
            .wdata   (pwdata[CNT_W-1:0]),
            .flags   (flags[c]),
            .load_q  (load_v[c]),
            .cnt_q   (cnt_v[c]),
            .irq     (irq[c])
         );

         // R9: a masked channel never drives its line
         p_mask_quiet_r9: assert property (@(posedge pclk) disable iff (!presetn)
            flags[c].masked |-> !irq[c]);

         // R11: the count of this channel moves only through its own state
         p_isolated_r11: assert property (@(posedge pclk) disable iff (!presetn)
            !flags[c].run && !rld_wr[c] |=> $stable(cnt_v[c]));
      end
   endgenerate

endmodule

// File: tb/sim_quad_countdown_timer.sv
module sim_quad_countdown_timer;

   localparam int NCH = 4;

   logic        pclk    = 1'b0;
   logic        presetn = 1'b0;
   logic        psel    = 1'b0;
   logic        penable = 1'b0;
   logic        pwrite  = 1'b0;
   logic [7:0]  paddr   = '0;
   logic [31:0] pwdata  = '0;
   logic [31:0] prdata;
   logic [3:0]  irq;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 pclk = ~pclk;

   quad_countdown_timer u0 (
      .pclk    (pclk),
      .presetn (presetn),
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .pwdata  (pwdata),
      .prdata  (prdata),
      .irq     (irq)
   );

   // ---------------- behavioural reference model ----------------
   bit [31:0] m_load [NCH];
   bit [31:0] m_cnt  [NCH];
   bit        m_one  [NCH];
   bit        m_run  [NCH];
   bit        m_mask [NCH];
   bit        m_pend [NCH];
   int        m_busy [NCH];

   task automatic m_reset();
      for (int c = 0; c < NCH; c++) begin
         m_load[c] = 0; m_cnt[c] = 0; m_one[c] = 0; m_run[c] = 0;
         m_mask[c] = 1; m_pend[c] = 0; m_busy[c] = 0;
      end
   endtask

   initial m_reset();

   always @(posedge pclk) begin
      if (!presetn) begin
         m_reset();
      end else begin
         for (int c = 0; c < NCH; c++) begin
            bit wr, exp_now, fin;
            bit [31:0] old_load;
            int off;
            wr       = psel && penable && pwrite && (int'(paddr[7:6]) == c);
            off      = int'(paddr[5:0]);
            exp_now  = m_run[c] && (m_cnt[c] == 0);
            fin      = (m_busy[c] == 1);
            old_load = m_load[c];
            if (m_busy[c] > 0) m_busy[c] = m_busy[c] - 1;
            else if (wr && off == 32 && pwdata[0]) m_busy[c] = 2;
            if (exp_now) m_pend[c] = 1;
            else if (fin) m_pend[c] = 0;
            if (wr && off == 20) m_cnt[c] = old_load;
            else if (m_run[c]) m_cnt[c] = exp_now ? (m_one[c] ? 0 : old_load) : m_cnt[c] - 1;
            if (wr && off == 16) m_run[c] = pwdata[0];
            else if (exp_now && m_one[c]) m_run[c] = 0;
            if (wr && off == 4)  m_one[c]  = pwdata[0];
            if (wr && off == 8)  m_load[c] = pwdata;
            if (wr && off == 36) m_mask[c] = pwdata[0];
         end
      end
   end

   function automatic bit [31:0] m_read(bit [7:0] a);
      int c = int'(a[7:6]);
      bit [31:0] r = 0;
      case (int'(a[5:0]))
         0:  for (int i = 0; i < NCH; i++) r[i] = m_pend[i];
         4:  r = {31'd0, m_one[c]};
         8:  r = m_load[c];
         16: r = {31'd0, m_run[c]};
         24: r = m_cnt[c];
         32: r = {30'd0, m_busy[c] > 0, m_pend[c]};
         36: r = {31'd0, m_mask[c]};
         default: r = 0;
      endcase
      return r;
   endfunction

   function automatic bit [3:0] m_irq();
      bit [3:0] r;
      for (int i = 0; i < NCH; i++) r[i] = m_pend[i] && !m_mask[i];
      return r;
   endfunction

   // ---------------- checking helpers ----------------
   task automatic chk(string tag, bit [31:0] act, bit [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // R9: interrupt lines against the model on every clock
   always @(negedge pclk) begin
      if (presetn && !done) chk("R9 irq per clock", {28'd0, irq}, {28'd0, m_irq()});
   end

   function automatic bit [7:0] adr(int ch, int off);
      return 8'(ch * 64 + off);
   endfunction

   task automatic expect_rd(bit [7:0] a, bit [31:0] exp, string tag);
      paddr = a;
      #1;
      chk(tag, prdata, exp);
   endtask

   task automatic peek(bit [7:0] a, string tag);
      paddr = a;
      #1;
      chk(tag, prdata, m_read(a));
   endtask

   task automatic wr(bit [7:0] a, bit [31:0] d);
      @(negedge pclk);
      psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
      @(negedge pclk);
      penable = 1;
      @(negedge pclk);
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      n_run++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      summary();
   end

   // ---------------- stimulus ----------------
   initial begin
      bit [31:0] held;
      repeat (3) @(negedge pclk);
      presetn = 1;

      // R10: reset values
      for (int ch = 0; ch < NCH; ch++) begin
         @(negedge pclk);
         expect_rd(adr(ch, 36), 1, "R10 mask after reset");
         expect_rd(adr(ch, 24), 0, "R10 count after reset");
         expect_rd(adr(ch, 16), 0, "R10 run after reset");
         expect_rd(adr(ch, 32), 0, "R10 clear reg after reset");
      end
      chk("R10 irq after reset", {28'd0, irq}, 0);

      // R1: load maximum, unmapped and misaligned offsets
      wr(adr(0, 8), 32'hFFFF_FFFF);
      expect_rd(adr(0, 8), 32'hFFFF_FFFF, "R1 load readback max");
      expect_rd(adr(0, 12), 0, "R1 unmapped 0x0C");
      expect_rd(adr(0, 60), 0, "R1 unmapped 0x3C");
      expect_rd(adr(0, 9), 0, "R1 misaligned 0x09");
      wr(adr(0, 12), 32'h1234_5678);
      for (int off = 0; off < 40; off += 4) begin
         @(negedge pclk);
         peek(adr(0, off), "R1 unmapped write left state");
      end

      // R5: reload regardless of data
      wr(adr(0, 20), 0);
      expect_rd(adr(0, 24), 32'hFFFF_FFFF, "R5 reload with data 0");
      wr(adr(0, 8), 100);
      wr(adr(0, 20), 1);
      expect_rd(adr(0, 24), 100, "R5 reload with data 1");

      // R2: decrement per clock once running
      wr(adr(0, 16), 1);
      expect_rd(adr(0, 24), 100, "R2 no step on enable edge");
      repeat (10) @(negedge pclk);
      expect_rd(adr(0, 24), 90, "R2 ten steps");
      wr(adr(0, 20), 0);
      expect_rd(adr(0, 24), 100, "R5 reload wins over decrement");

      // R6: hold while stopped
      wr(adr(0, 16), 0);
      paddr = adr(0, 24);
      #1;
      held = prdata;
      repeat (5) @(negedge pclk);
      expect_rd(adr(0, 24), held, "R6 count held");

      // R3: free-running period on channel 1
      wr(adr(1, 8), 4);
      wr(adr(1, 20), 0);
      wr(adr(1, 36), 0);
      wr(adr(1, 16), 1);
      repeat (4) @(negedge pclk);
      expect_rd(adr(1, 32), 0, "R3 no early expiry");
      expect_rd(adr(1, 24), 0, "R3 count at zero");
      @(negedge pclk);
      expect_rd(adr(1, 32), 1, "R3 pending after L+1");
      expect_rd(adr(1, 24), 4, "R3 restart from load");
      expect_rd(adr(2, 0), 2, "R1 status in other window");
      chk("R9 irq raised", {31'd0, irq[1]}, 1);
      repeat (12) @(negedge pclk);

      // R9: masking
      wr(adr(1, 36), 1);
      chk("R9 masked line low", {31'd0, irq[1]}, 0);
      wr(adr(1, 36), 0);
      chk("R9 unmasked line high", {31'd0, irq[1]}, 1);

      // R7: clear path
      wr(adr(1, 16), 0);
      wr(adr(1, 32), 0);
      expect_rd(adr(1, 32), 1, "R7 write 0 no effect");
      wr(adr(1, 32), 1);
      expect_rd(adr(1, 32), 3, "R7 busy first cycle");
      @(negedge pclk);
      expect_rd(adr(1, 32), 3, "R7 busy second cycle");
      @(negedge pclk);
      expect_rd(adr(1, 32), 0, "R7 flag dropped after window");
      chk("R7 irq low after clear", {31'd0, irq[1]}, 0);

      // R4: one-shot on channel 1
      wr(adr(1, 4), 1);
      wr(adr(1, 20), 0);
      wr(adr(1, 16), 1);
      repeat (8) @(negedge pclk);
      expect_rd(adr(1, 16), 0, "R4 run cleared");
      expect_rd(adr(1, 24), 0, "R4 count stays zero");
      expect_rd(adr(1, 32), 1, "R4 pending set");

      // R8: clear write held across two edges
      @(negedge pclk);
      psel = 1; pwrite = 1; penable = 0; paddr = adr(1, 32); pwdata = 1;
      @(negedge pclk);
      penable = 1;
      @(negedge pclk);
      @(negedge pclk);
      psel = 0; penable = 0; pwrite = 0;
      expect_rd(adr(1, 32), 3, "R8 window still open");
      @(negedge pclk);
      expect_rd(adr(1, 32), 0, "R8 window not extended");

      // R11: untouched channels and per-window writes
      wr(adr(2, 8), 32'h55);
      expect_rd(adr(2, 8), 32'h55, "R1 channel 2 window");
      expect_rd(adr(3, 8), 0, "R11 channel 3 load untouched");
      expect_rd(adr(3, 36), 1, "R11 channel 3 mask untouched");
      expect_rd(adr(1, 8), 4, "R11 channel 1 load untouched");

      // Full sweep against the model
      for (int ch = 0; ch < NCH; ch++) begin
         for (int off = 0; off < 40; off += 4) begin
            @(negedge pclk);
            peek(adr(ch, off), "R11 sweep vs model");
         end
      end

      done = 1'b1;
      summary();
   end

endmodule